// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block converts CAN identifiers between their numeric form and the four-byte identifier image a CAN controller keeps in its message buffers. It also decides whether a received frame is wanted. A numeric identifier goes in with a flag that says standard (11-bit) or extended (29-bit). The block returns the 32-bit image ready for transmission, laid out as the split byte format that the receive path expects.

On the receive side, a strobe presents a four-byte image. The block recovers the numeric identifier and the extended flag from that image. In the same step it compares the image against a bank of 32-bit code/mask filters. In the mode where both mode bits are zero, two independent filters run. A frame is accepted when any filter matches, and the lowest-numbered matching filter is reported. The accept flag, the filter index and the decoded identifier are all registered, so they appear one cycle after the strobe.

The image is carried as a 32-bit vector with byte 0 in bits 31:24, byte 1 in bits 23:16, byte 2 in bits 15:8 and byte 3 in bits 7:0. Bit N of byte B is therefore image bit 8*(3-B)+N.

Top module: `can_id_filter`

## Requirements
- R1: With `tx_ext`=0, `tx_image` holds id[10:3] in byte 0 and id[2:0] in byte 1 bits 7..5. Every other bit is zero, including IDE (byte 1 bit 3, image bit 19). Identifier bits above 10 are ignored.
- R2: With `tx_ext`=1, `tx_image` is laid out as follows. Byte 0 holds id[28:21]. Byte 1 holds id[20:18] in bits 7..5, a zero in bit 4, IDE=1 in bit 3, and id[17:15] in bits 2..0. Byte 2 holds id[14:7]. Byte 3 holds id[6:0] in bits 7..1 and a zero in bit 0.
- R3: A received image is decoded as extended when image bit 19 is 1, and as standard when it is 0. The decoding inverts the R1/R2 layouts. A standard identifier is zero-extended to 29 bits. `id_ext` reports the IDE bit.
- R4: A mask bit of 1 makes the matching image bit don't-care. A mask bit of 0 requires that image bit to equal the code bit.
- R5: Filter 0 uses `flt_code[63:32]` and `flt_mask[63:32]`. Filter 1 uses `flt_code[31:0]` and `flt_mask[31:0]`.
- R6: A frame is accepted when at least one filter matches. `acc_idx` gives the lowest-numbered matching filter, so it is 0 when both match.
- R7: `acc_valid` is high for exactly the cycle after a cycle with `rx_valid` high. The accept flag, the index and the decoded identifier for that strobe are valid in that same cycle.
- R8: When `flt_mode` is not 00, no frame is accepted. The identifier is still decoded.
- R9: After reset, `acc_valid`, `acc_hit`, `acc_idx`, `id_out` and `id_ext` are all zero.
- R10: `acc_hit` is high only together with `acc_valid`. `acc_idx`, `id_out` and `id_ext` keep their values through cycles that have no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_id | input | 29 | Numeric identifier to pack |
| tx_ext | input | 1 | 1 = pack as extended identifier |
| tx_image | output | 32 | Packed identifier image (combinational) |
| rx_valid | input | 1 | Receive strobe, one cycle per frame |
| rx_image | input | 32 | Received identifier image |
| flt_mode | input | 2 | Filter mode; 00 = two 32-bit filters |
| flt_code | input | 64 | Filter codes, filter 0 in the upper word |
| flt_mask | input | 64 | Filter masks, 1 = don't care |
| acc_valid | output | 1 | Result valid pulse |
| acc_hit | output | 1 | Frame accepted |
| acc_idx | output | 1 | Index of the matching filter |
| id_out | output | 29 | Decoded identifier |
| id_ext | output | 1 | Decoded frame was extended |

## Verification
Received images are produced by packing random identifiers. Half of them are the filter target exactly, and half have a single bit flipped. Single-bit flips inside the masked region must still be accepted, and flips outside it must be rejected, which tells apart a mask polarity or bit-position error. Directed cases cover four situations: both filters matching, only filter 1 matching, an all-ones mask, and a standard frame against an extended-coded filter (IDE mismatch). These separate the priority rule from the filter-to-slice mapping. Non-zero modes and idle cycles after a strobe show that blocking and holding behave as required.

// File: rtl/can_idf_pkg.sv
// Package: shared widths and bit positions for the identifier image.
// Assumes a 32-bit image with byte 0 in the most significant byte.
package can_idf_pkg;
    localparam int IMG_W   = 32;
    localparam int EXT_W   = 29;
    localparam int STD_W   = 11;
    localparam int IDE_POS = 19;
    localparam int MODE_W  = 2;
    typedef logic [IMG_W-1:0] img_t;
    typedef logic [EXT_W-1:0] ext_id_t;
endpackage

// File: rtl/can_idf_pack.sv
// Module: packs a numeric identifier into the transmit image.
// Assumes id bits above STD_W-1 are ignored for standard frames.
module can_idf_pack
    import can_idf_pkg::*;
(
    input  ext_id_t id,
    input  logic    ext,
    output img_t    img
);
    localparam int STD_SHIFT = IMG_W - STD_W;

    // Select the standard or extended bit layout.
    always_comb begin
        if (ext) begin
            img = {id[28:18], 1'b0, 1'b1, id[17:15], id[14:7], id[6:0], 1'b0};
        end else begin
            img = {id[STD_W-1:0], {STD_SHIFT{1'b0}}};
        end
    end
endmodule

// File: rtl/can_idf_unpack.sv
// Module: recovers the numeric identifier and IDE flag from an image.
// Assumes the image follows the layout produced by can_idf_pack.
module can_idf_unpack
    import can_idf_pkg::*;
(
    input  img_t    img,
    output ext_id_t id,
    output logic    ext
);
    localparam int PAD_W = EXT_W - STD_W;

    // Decode according to the IDE bit.
    always_comb begin
        ext = img[IDE_POS];
        if (ext) begin
            id = {img[31:21], img[18:16], img[15:8], img[7:1]};
        end else begin
            id = {{PAD_W{1'b0}}, img[31:21]};
        end
    end
endmodule

// File: rtl/can_idf_match.sv
// Module: one code/mask comparator; a mask bit of 1 is don't-care.
// Assumes code, mask and image share the same bit layout.
module can_idf_match
    import can_idf_pkg::*;
(
    input  img_t img,
    input  img_t code,
    input  img_t mask,
    output logic hit
);
    // Compare only the bits whose mask bit is clear.
    always_comb begin
        hit = (((img ^ code) & ~mask) == '0);
    end
endmodule

// File: rtl/can_id_filter.sv
// Module: top of the identifier acceptance filter. It packs transmit
// identifiers combinationally and registers the receive decode and filter
// result one cycle after rx_valid. Assumes filter k takes the k-th 32-bit
// word counted from the top of flt_code/flt_mask.
module can_id_filter
    import can_idf_pkg::*;
#(
    parameter int NUM_FILT = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [EXT_W-1:0]          tx_id,
    input  logic                      tx_ext,
    output logic [IMG_W-1:0]          tx_image,
    input  logic                      rx_valid,
    input  logic [IMG_W-1:0]          rx_image,
    input  logic [MODE_W-1:0]         flt_mode,
    input  logic [NUM_FILT*IMG_W-1:0] flt_code,
    input  logic [NUM_FILT*IMG_W-1:0] flt_mask,
    output logic                      acc_valid,
    output logic                      acc_hit,
    output logic [((NUM_FILT>1)?$clog2(NUM_FILT):1)-1:0] acc_idx,
    output logic [EXT_W-1:0]          id_out,
    output logic                      id_ext
);
    localparam int IDX_W = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1;

    logic [NUM_FILT-1:0] hit_vec;
    logic                any_hit;
    logic [IDX_W-1:0]    first_idx;
    ext_id_t             dec_id;
    logic                dec_ext;
    logic                mode_ok;

    can_idf_pack u_pack (.id(tx_id), .ext(tx_ext), .img(tx_image));

    can_idf_unpack u_unpack (.img(rx_image), .id(dec_id), .ext(dec_ext));

    genvar g;
    generate
        for (g = 0; g < NUM_FILT; g++) begin : g_filt
            can_idf_match u_match (
                .img (rx_image),
                .code(flt_code[(NUM_FILT-g)*IMG_W-1 -: IMG_W]),
                .mask(flt_mask[(NUM_FILT-g)*IMG_W-1 -: IMG_W]),
                .hit (hit_vec[g])
            );
        end
    endgenerate

    // Pick the lowest-numbered matching filter.
    always_comb begin
        any_hit   = 1'b0;
        first_idx = '0;
        for (int k = NUM_FILT - 1; k >= 0; k--) begin
            if (hit_vec[k]) begin
                any_hit   = 1'b1;
                first_idx = IDX_W'(k);
            end
        end
    end

    // Only the dual 32-bit mode accepts frames.
    always_comb begin
        mode_ok = (flt_mode == '0);
    end

    // Register the result on a strobe; hold the decode otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_valid <= 1'b0;
            acc_hit   <= 1'b0;
            acc_idx   <= '0;
            id_out    <= '0;
            id_ext    <= 1'b0;
        end else begin
            acc_valid <= rx_valid;
            acc_hit   <= rx_valid && mode_ok && any_hit;
            if (rx_valid) begin
                acc_idx <= first_idx;
                id_out  <= dec_id;
                id_ext  <= dec_ext;
            end
        end
    end

    // R7: the result pulse follows each strobe by one cycle.
    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> acc_valid);
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !acc_valid);
    // R8: a non-zero mode never accepts.
    p_mode_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && flt_mode != '0) |=> !acc_hit);
    // R10: the hit flag only appears with the valid pulse.
    p_hit_qualified_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit |-> acc_valid);
    // R10: the decode holds through idle cycles.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> ($stable(id_out) && $stable(id_ext) && $stable(acc_idx)));
    // R3: the extended flag follows the IDE bit of the strobed image.
    p_ide_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (id_ext == $past(rx_image[IDE_POS])));
    // R6: a filter-0 match while enabled is always accepted at index 0.
    p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mode_ok && hit_vec[0]) |=> (acc_hit && acc_idx == '0));
endmodule

// File: tb/sim_can_id_filter.sv
`timescale 1ns/1ps
module sim_can_id_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [28:0] tx_id = '0;
    logic        tx_ext = 1'b0;
    logic [31:0] tx_image;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_image = '0;
    logic [1:0]  flt_mode = '0;
    logic [63:0] flt_code = '0;
    logic [63:0] flt_mask = '0;
    logic        acc_valid, acc_hit;
    logic [0:0]  acc_idx;
    logic [28:0] id_out;
    logic        id_ext;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    can_id_filter u0 (
        .clk(clk), .rst_n(rst_n), .tx_id(tx_id), .tx_ext(tx_ext),
        .tx_image(tx_image), .rx_valid(rx_valid), .rx_image(rx_image),
        .flt_mode(flt_mode), .flt_code(flt_code), .flt_mask(flt_mask),
        .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_idx(acc_idx),
        .id_out(id_out), .id_ext(id_ext)
    );

    function automatic logic [31:0] ref_pack(logic [28:0] id, logic ext);
        logic [31:0] r = '0;
        if (ext) begin
            r[31:24] = id[28:21];
            r[23:21] = id[20:18];
            r[19]    = 1'b1;
            r[18:16] = id[17:15];
            r[15:8]  = id[14:7];
            r[7:1]   = id[6:0];
        end else begin
            r[31:24] = id[10:3];
            r[23:21] = id[2:0];
        end
        return r;
    endfunction

    function automatic logic [29:0] ref_decode(logic [31:0] im);
        if (im[19])
            return {1'b1, im[31:24], im[23:21], im[18:16], im[15:8], im[7:1]};
        return {1'b0, 18'd0, im[31:24], im[23:21]};
    endfunction

    function automatic bit ref_hit(logic [31:0] im, logic [31:0] c, logic [31:0] m);
        for (int b = 0; b < 32; b++)
            if (!m[b] && im[b] != c[b]) return 0;
        return 1;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Strobe one image and check the registered result (R3..R8, R10).
    task automatic strobe(logic [31:0] im, string tag);
        bit h0, h1, ex_hit;
        logic [29:0] dec;
        @(negedge clk);
        rx_image = im;
        rx_valid = 1'b1;
        h0 = ref_hit(im, flt_code[63:32], flt_mask[63:32]);
        h1 = ref_hit(im, flt_code[31:0], flt_mask[31:0]);
        ex_hit = (flt_mode == 2'b00) && (h0 || h1);
        dec = ref_decode(im);
        @(negedge clk);
        rx_valid = 1'b0;
        chk({"R7 valid ", tag}, acc_valid, 1);
        chk({"R4/R5/R6/R8 hit ", tag}, acc_hit, ex_hit);
        if (ex_hit) chk({"R6 idx ", tag}, acc_idx, h0 ? 0 : 1);
        chk({"R3 id ", tag}, id_out, dec[28:0]);
        chk({"R3 ext ", tag}, id_ext, dec[29]);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [28:0] tid, fid;
        logic [31:0] im, last_id;
        bit e;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R9: reset state.
        chk("R9 valid", acc_valid, 0);
        chk("R9 hit", acc_hit, 0);
        chk("R9 idx", acc_idx, 0);
        chk("R9 id", id_out, 0);
        chk("R9 ext", id_ext, 0);
        rst_n = 1'b1;

        // R1: standard packing, upper bits ignored.
        tx_ext = 0; tx_id = 29'h1FFF_F7A5; #1;
        chk("R1 std pack", tx_image, ref_pack(29'h7A5, 0));
        tx_id = 29'h0000_0001; #1;
        chk("R1 std pack lsb", tx_image, 32'h0020_0000);
        // R2: extended packing.
        tx_ext = 1; tx_id = 29'h1FFF_FFFF; #1;
        chk("R2 ext pack ones", tx_image, 32'hFFEF_FFFE);
        for (int i = 0; i < 40; i++) begin
            tx_id = 29'($urandom); tx_ext = 1'($urandom); #1;
            chk("R1/R2 pack random", tx_image, ref_pack(tx_id, tx_ext));
        end

        // R6: both filters match -> index 0.
        flt_code = {ref_pack(29'h123, 0), ref_pack(29'h123, 0)};
        flt_mask = '0;
        strobe(ref_pack(29'h123, 0), "both");
        // R5: only filter 1 matches.
        flt_code = {ref_pack(29'h124, 0), ref_pack(29'h123, 0)};
        strobe(ref_pack(29'h123, 0), "f1 only");
        chk("R5 idx f1", acc_idx, 1);
        // R4: all-ones mask accepts anything on filter 0.
        flt_mask = {32'hFFFF_FFFF, 32'h0};
        strobe(32'hDEAD_BEEF, "mask ones");
        // R4: IDE mismatch rejected when IDE is not masked.
        flt_code = {ref_pack(29'h123, 1), ref_pack(29'h123, 1)};
        flt_mask = '0;
        strobe(ref_pack(29'h123, 0), "ide mismatch");
        chk("R4 ide reject", acc_hit, 0);
        // R8: non-zero mode blocks a perfect match.
        flt_code = {ref_pack(29'h0ABCDEF, 1), 32'h0};
        flt_mode = 2'b01;
        strobe(ref_pack(29'h0ABCDEF, 1), "mode01");
        chk("R8 blocked", acc_hit, 0);
        chk("R8 decoded", id_out, 29'h0ABCDEF);
        flt_mode = 2'b11;
        strobe(ref_pack(29'h0ABCDEF, 1), "mode11");
        flt_mode = 2'b00;
        // R7/R10: idle cycle drops valid and hit, holds decode.
        last_id = {3'b0, id_out};
        @(negedge clk);
        chk("R7 pulse ends", acc_valid, 0);
        chk("R10 hit drops", acc_hit, 0);
        chk("R10 id holds", id_out, last_id[28:0]);
        chk("R10 ext holds", id_ext, 1);

        // Random mix of exact matches and single-bit flips.
        for (int i = 0; i < 400; i++) begin
            tid = 29'($urandom); e = 1'($urandom);
            if (!e) tid[28:11] = '0;
            fid = tid;
            if ($urandom_range(1, 0) == 1) fid[$urandom_range(e ? 28 : 10, 0)] ^= 1'b1;
            flt_code = {ref_pack(tid, e), ref_pack(29'($urandom), 1'($urandom))};
            flt_mask = {($urandom_range(3, 0) == 0) ? 32'($urandom) & 32'h00FF_00FF : 32'h0,
                        32'($urandom) & 32'h0000_FFFF};
            flt_mode = ($urandom_range(7, 0) == 0) ? 2'($urandom) : 2'b00;
            im = ref_pack(fid, e);
            strobe(im, "random");
            if ($urandom_range(3, 0) == 0) begin
                @(negedge clk);
                chk("R7 random idle", acc_valid, 0);
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule